// File: doc/BRIEF.md
# ATA PIO Port Decoder and Sequencer

This block sits between a host I/O request stream and two ATA cables. Each host request carries an address, byte enables and write data. The block checks whether the address falls in one of the register windows of either channel. On a hit it drives the matching chip select, the three-bit device address and a read or write strobe on that cable, and then returns a response carrying the read data. Each channel decodes either its fixed legacy windows or two programmable native base addresses, and the mode bit is separate for each channel.

Strobe timing is set per access. Every register except the data port uses a slow compatible cycle of 3 setup, 8 strobe and 6 recovery clocks. The data port can use a fast cycle whose setup, strobe and recovery counts come from a timing field of the currently selected drive. The selected drive comes from a shadow of bit 4 of the last write to the drive/head register. A 32-bit data-port access becomes two 16-bit strobe cycles.

Both stream interfaces use valid/ready. A request is taken only while the block is idle, because `req_ready` is low from acceptance until the response is consumed. A response stays valid with unchanged contents until `rsp_ready` is seen high. An access that hits no window is still accepted. It is answered at once with `rsp_hit` low and produces no cable activity.

Top module: `ata_pio_ctrl`

## Requirements
- R1: In legacy mode, addresses 1F0h-1F7h (channel 0) and 170h-177h (channel 1) assert that channel's `ata_cs1_n` low, with `ata_da` equal to address bits [2:0].
- R2: In legacy mode, addresses 3F4h-3F7h (channel 0) and 374h-377h (channel 1) assert that channel's `ata_cs3_n` low, with `ata_da` equal to 4 plus address bits [1:0].
- R3: At most one chip select is active at any time. A strobe goes low only inside an active chip select: `ata_rd_n` for reads and `ata_wr_n` for writes, on the selected channel only.
- R4: When `native_mode[c]` is 1, channel c decodes an 8-byte command window at `native_cmd_base[16c+15:16c]` (low 3 bits ignored) and a 4-byte control window at `native_ctl_base[16c+15:16c]` (low 2 bits ignored), and it ignores its legacy windows. When the bit is 0, the channel ignores the native windows.
- R5: Channel c decodes nothing unless both `io_en` and `chan_en[c]` are 1. A miss is accepted and answered with `rsp_hit`=0 and `rsp_rdata`=0, and no chip select becomes active.
- R6: Every non-data register, and the data port when fast timing is off for the selected drive, uses 3 setup clocks (chip select active, strobe high), 8 strobe clocks and 6 recovery clocks.
- R7: The data port (command offset 0) uses fast timing when `fast_en[2c+d]` is 1 for channel c and drive d. The field at `fast_timing[6(2c+d)+5 : 6(2c+d)]` holds recovery-1 in bits [5:4], strobe-1 in bits [3:2] and setup-1 in bits [1:0].
- R8: Each channel keeps a drive bit that resets to 0 and takes `req_wdata[4]` on every accepted hit write to command offset 6. That bit selects which drive's timing applies.
- R9: A data-port access with `req_be`=4'hF performs two 16-bit strobe cycles. The low half goes first, and the response follows the second cycle. Any other byte-enable value gives one 16-bit cycle.
- R10: A non-data register transfers one byte: `ata_dout` is {8'h00, wdata[7:0]}, and a read returns {24'h0, din[7:0]}.
- R11: `req_ready` is high only while idle. Once raised, `rsp_valid` stays high with stable `rsp_rdata` until `rsp_ready` is high.
- R12: Read data is taken from the channel's 16-bit `ata_din` lane on the last strobe clock of each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_en | input | 1 | Global I/O decode enable |
| chan_en | input | 2 | Per-channel decode enable |
| native_mode | input | 2 | Per-channel native (1) or legacy (0) decode |
| native_cmd_base | input | 32 | Native command window base, 16 bits per channel |
| native_ctl_base | input | 32 | Native control window base, 16 bits per channel |
| fast_en | input | 4 | Fast data-port timing enable, index 2*channel+drive |
| fast_timing | input | 24 | Fast timing fields, 6 bits per drive |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | I/O address |
| req_be | input | 4 | Byte enables (4'hF = 32-bit) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response ready |
| rsp_hit | output | 1 | Request hit a decoded window |
| rsp_rdata | output | 32 | Read data |
| ata_cs1_n | output | 2 | Command-window chip select per channel, active low |
| ata_cs3_n | output | 2 | Control-window chip select per channel, active low |
| ata_rd_n | output | 2 | Read strobe per channel, active low |
| ata_wr_n | output | 2 | Write strobe per channel, active low |
| ata_da | output | 3 | Device register address |
| ata_dout | output | 16 | Write data to cable |
| ata_dout_oe | output | 1 | Write data output enable |
| ata_din | input | 32 | Read data, 16 bits per channel |

## Verification
The assertions assume that the configuration inputs (`io_en`, `chan_en`, `native_mode`, bases and timing) stay constant while a transfer is in flight, and that native windows do not overlap the other channel's windows. The bench changes configuration only between transactions, after the response has been consumed. The strobe-width property also assumes that the latched timing counts match the access type. The bench checks this independently by measuring setup, pulse width and total select time on the cable. Read data on `ata_din` changes only after a strobe pulse has ended, so the value sampled on the last strobe clock is always well defined.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_SETUP,
    SQ_STROBE,
    SQ_RECOV,
    SQ_RESP
  } seq_state_t;
endpackage

// File: rtl/ata_chan_decode.sv
module ata_chan_decode #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] LEG_CMD = 16'h01F0,
  parameter logic [ADDR_W-1:0] LEG_CTL = 16'h03F4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              native,
  input  logic              enable,
  input  logic [ADDR_W-1:0] cmd_base,
  input  logic [ADDR_W-1:0] ctl_base,
  output logic              hit_cmd,
  output logic              hit_ctl
);
  localparam logic [ADDR_W-1:0] CMD_MASK = ~(ADDR_W'(7));
  localparam logic [ADDR_W-1:0] CTL_MASK = ~(ADDR_W'(3));

  logic [ADDR_W-1:0] cb, kb;

  always_comb begin
    cb = native ? cmd_base : LEG_CMD;
    kb = native ? ctl_base : LEG_CTL;
    hit_cmd = enable && (((addr ^ cb) & CMD_MASK) == '0);
    hit_ctl = enable && (((addr ^ kb) & CTL_MASK) == '0);
  end

  // R4: a native channel never answers its legacy command window
  always_comb begin
    if (enable && native && (((addr ^ LEG_CMD) & CMD_MASK) == '0)
        && (((cmd_base ^ LEG_CMD) & CMD_MASK) != '0))
      assert_legacy_ignored_R4: assert (!hit_cmd);
  end
endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq
  import ata_pio_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_hit,
  input  logic             start_two,
  input  logic [CNT_W-1:0] t_setup,
  input  logic [CNT_W-1:0] t_strobe,
  input  logic [CNT_W-1:0] t_recov,
  input  logic [31:0]      wdata,
  input  logic [15:0]      din,
  input  logic             rsp_ready,
  output logic             idle,
  output logic             cs_act,
  output logic             strb_act,
  output logic [15:0]      dout,
  output logic             rsp_valid,
  output logic [31:0]      rdata
);
  seq_state_t       st;
  logic [CNT_W-1:0] cnt, s_q, t_q, r_q, run;
  logic             half, two_q;
  logic [31:0]      wd_q, rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= SQ_IDLE; cnt <= '0; s_q <= '0; t_q <= '0; r_q <= '0;
      half <= 1'b0; two_q <= 1'b0; wd_q <= '0; rd_q <= '0;
    end else begin
      case (st)
        SQ_IDLE: if (start) begin
          two_q <= start_two; s_q <= t_setup; t_q <= t_strobe; r_q <= t_recov;
          wd_q <= wdata; rd_q <= '0; half <= 1'b0;
          if (start_hit) begin st <= SQ_SETUP; cnt <= t_setup - 1'b1; end
          else st <= SQ_RESP;
        end
        SQ_SETUP:
          if (cnt == '0) begin st <= SQ_STROBE; cnt <= t_q - 1'b1; end
          else cnt <= cnt - 1'b1;
        SQ_STROBE:
          if (cnt == '0) begin
            if (half) rd_q[31:16] <= din; else rd_q[15:0] <= din;
            st <= SQ_RECOV; cnt <= r_q - 1'b1;
          end else cnt <= cnt - 1'b1;
        SQ_RECOV:
          if (cnt == '0) begin
            if (two_q && !half) begin half <= 1'b1; st <= SQ_SETUP; cnt <= s_q - 1'b1; end
            else st <= SQ_RESP;
          end else cnt <= cnt - 1'b1;
        SQ_RESP: if (rsp_ready) st <= SQ_IDLE;
        default: st <= SQ_IDLE;
      endcase
    end
  end

  // strobe run-length monitor used by the width check
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= '0;
    else if (st == SQ_STROBE) run <= run + 1'b1;
    else if (st == SQ_SETUP) run <= '0;
  end

  assign idle      = (st == SQ_IDLE);
  assign cs_act    = (st == SQ_SETUP) || (st == SQ_STROBE) || (st == SQ_RECOV);
  assign strb_act  = (st == SQ_STROBE);
  assign dout      = half ? wd_q[31:16] : wd_q[15:0];
  assign rsp_valid = (st == SQ_RESP);
  assign rdata     = rd_q;

  // R6 R7: the strobe lasted exactly the latched count
  assert_strobe_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_RECOV) |-> (run == t_q));
  // R9: a two-part access answers only after its second half
  assert_two_halves_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_RESP && $past(st) == SQ_RECOV && two_q) |-> half);
endmodule

// File: rtl/ata_pio_ctrl.sv
module ata_pio_ctrl #(
  parameter int ADDR_W = 16,
  parameter int FAST_W = 2,
  parameter logic [ADDR_W-1:0] PRI_CMD = 16'h01F0,
  parameter logic [ADDR_W-1:0] PRI_CTL = 16'h03F4,
  parameter logic [ADDR_W-1:0] SEC_CMD = 16'h0170,
  parameter logic [ADDR_W-1:0] SEC_CTL = 16'h0374,
  parameter int COMPAT_SETUP  = 3,
  parameter int COMPAT_STROBE = 8,
  parameter int COMPAT_RECOV  = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  io_en,
  input  logic [1:0]            chan_en,
  input  logic [1:0]            native_mode,
  input  logic [2*ADDR_W-1:0]   native_cmd_base,
  input  logic [2*ADDR_W-1:0]   native_ctl_base,
  input  logic [3:0]            fast_en,
  input  logic [4*3*FAST_W-1:0] fast_timing,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [3:0]            req_be,
  input  logic [31:0]           req_wdata,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic                  rsp_hit,
  output logic [31:0]           rsp_rdata,
  output logic [1:0]            ata_cs1_n,
  output logic [1:0]            ata_cs3_n,
  output logic [1:0]            ata_rd_n,
  output logic [1:0]            ata_wr_n,
  output logic [2:0]            ata_da,
  output logic [15:0]           ata_dout,
  output logic                  ata_dout_oe,
  input  logic [31:0]           ata_din
);
  localparam int NCH   = 2;
  localparam int FLD_W = 3 * FAST_W;
  localparam int TM1   = (COMPAT_SETUP > COMPAT_STROBE) ? COMPAT_SETUP : COMPAT_STROBE;
  localparam int TM2   = (TM1 > COMPAT_RECOV) ? TM1 : COMPAT_RECOV;
  localparam int TMAX  = (TM2 > (1 << FAST_W)) ? TM2 : (1 << FAST_W);
  localparam int CNT_W = $clog2(TMAX + 1);

  logic [NCH-1:0] hit_cmd, hit_ctl, drv_shadow;

  for (genvar c = 0; c < NCH; c++) begin : g_dec
    ata_chan_decode #(
      .ADDR_W (ADDR_W),
      .LEG_CMD((c == 0) ? PRI_CMD : SEC_CMD),
      .LEG_CTL((c == 0) ? PRI_CTL : SEC_CTL)
    ) u_dec (
      .addr    (req_addr),
      .native  (native_mode[c]),
      .enable  (io_en && chan_en[c]),
      .cmd_base(native_cmd_base[c*ADDR_W +: ADDR_W]),
      .ctl_base(native_ctl_base[c*ADDR_W +: ADDR_W]),
      .hit_cmd (hit_cmd[c]),
      .hit_ctl (hit_ctl[c])
    );
  end

  // request classification
  logic             any_hit, sel_ch, sel_cmd, data_port, two, use_fast, fire;
  logic [1:0]       didx;
  logic [FLD_W-1:0] fld;
  logic [2:0]       da;
  logic [CNT_W-1:0] ts, tt, tr;

  always_comb begin
    any_hit   = |{hit_cmd, hit_ctl};
    sel_ch    = !(hit_cmd[0] || hit_ctl[0]);
    sel_cmd   = hit_cmd[sel_ch];
    da        = sel_cmd ? req_addr[2:0] : {1'b1, req_addr[1:0]};
    data_port = sel_cmd && (req_addr[2:0] == 3'd0);
    two       = data_port && (req_be == 4'hF);
    didx      = {sel_ch, drv_shadow[sel_ch]};
    use_fast  = data_port && fast_en[didx];
    fld       = fast_timing[didx*FLD_W +: FLD_W];
    ts = use_fast ? {{(CNT_W-FAST_W){1'b0}}, fld[FAST_W-1:0]} + 1'b1 : CNT_W'(COMPAT_SETUP);
    tt = use_fast ? {{(CNT_W-FAST_W){1'b0}}, fld[2*FAST_W-1:FAST_W]} + 1'b1 : CNT_W'(COMPAT_STROBE);
    tr = use_fast ? {{(CNT_W-FAST_W){1'b0}}, fld[3*FAST_W-1:2*FAST_W]} + 1'b1 : CNT_W'(COMPAT_RECOV);
  end

  logic idle, cs_act, strb_act;
  logic [15:0] seq_dout;
  logic [31:0] seq_rdata;
  logic ch_q, cmd_q, wr_q, narrow_q, hit_q;
  logic [2:0] da_q;

  assign req_ready = idle;
  assign fire      = req_valid && idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q <= 1'b0; cmd_q <= 1'b0; wr_q <= 1'b0; narrow_q <= 1'b0;
      hit_q <= 1'b0; da_q <= '0; drv_shadow <= '0;
    end else if (fire) begin
      ch_q <= sel_ch; cmd_q <= sel_cmd; wr_q <= req_write;
      narrow_q <= !data_port; hit_q <= any_hit; da_q <= da;
      if (any_hit && req_write && sel_cmd && req_addr[2:0] == 3'd6)
        drv_shadow[sel_ch] <= req_wdata[4];
    end
  end

  ata_pio_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(fire), .start_hit(any_hit), .start_two(two),
    .t_setup(ts), .t_strobe(tt), .t_recov(tr), .wdata(req_wdata),
    .din(ata_din[ch_q*16 +: 16]), .rsp_ready(rsp_ready),
    .idle(idle), .cs_act(cs_act), .strb_act(strb_act), .dout(seq_dout),
    .rsp_valid(rsp_valid), .rdata(seq_rdata)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_pins
    assign ata_cs1_n[c] = !(cs_act && ch_q == c && cmd_q);
    assign ata_cs3_n[c] = !(cs_act && ch_q == c && !cmd_q);
    assign ata_rd_n[c]  = !(strb_act && ch_q == c && !wr_q);
    assign ata_wr_n[c]  = !(strb_act && ch_q == c && wr_q);
  end

  assign ata_da      = da_q;
  assign ata_dout    = narrow_q ? {8'h00, seq_dout[7:0]} : seq_dout;
  assign ata_dout_oe = cs_act && wr_q;
  assign rsp_hit     = hit_q;
  assign rsp_rdata   = narrow_q ? {24'h0, seq_rdata[7:0]} : seq_rdata;

  assert_one_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~{ata_cs3_n, ata_cs1_n}));
  assert_strobe_in_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&ata_rd_n) || !(&ata_wr_n)) |-> !(&{ata_cs3_n, ata_cs1_n}));
  assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !io_en) |=> (&{ata_cs3_n, ata_cs1_n}));
  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
endmodule

// File: tb/tb_ata_pio_ctrl.sv
`timescale 1ns/1ps
module tb_ata_pio_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic io_en; logic [1:0] chan_en, native_mode;
  logic [31:0] native_cmd_base, native_ctl_base;
  logic [3:0] fast_en; logic [23:0] fast_timing;
  logic req_valid, req_ready, req_write; logic [15:0] req_addr;
  logic [3:0] req_be; logic [31:0] req_wdata;
  logic rsp_valid, rsp_ready, rsp_hit; logic [31:0] rsp_rdata;
  logic [1:0] ata_cs1_n, ata_cs3_n, ata_rd_n, ata_wr_n;
  logic [2:0] ata_da; logic [15:0] ata_dout; logic ata_dout_oe;
  logic [31:0] ata_din;

  ata_pio_ctrl dut (.*);

  int nchk = 0, nfail = 0, cyc = 0;
  // cable monitor
  int tx_cyc, npulse, gap, cur; int pw [2]; logic [15:0] pdout [2];
  logic [3:0] pcs; logic [2:0] pda; logic prev_strb = 1'b0;
  logic [15:0] din_base = 16'h0000;

  always @(negedge clk) begin
    logic strb, csa;
    strb = !(&ata_rd_n) || !(&ata_wr_n);
    csa  = !(&{ata_cs3_n, ata_cs1_n});
    if (csa) tx_cyc++;
    if (csa && !strb && npulse == 0 && !prev_strb) gap++;
    if (strb && !prev_strb) begin
      cur = 1; pcs = ~{ata_cs3_n, ata_cs1_n}; pda = ata_da;
      if (npulse < 2) pdout[npulse] = ata_dout;
    end else if (strb) cur++;
    if (!strb && prev_strb) begin
      if (npulse < 2) pw[npulse] = cur;
      npulse++;
    end
    prev_strb = strb;
    ata_din = {2{din_base + 16'h1111 * 16'(npulse)}};
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 60000) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_io(input logic wr, input logic [15:0] a, input logic [3:0] be,
                       input logic [31:0] wd, output logic [31:0] rd, output logic hit);
    int w;
    @(negedge clk);
    tx_cyc = 0; npulse = 0; gap = 0; cur = 0; pcs = 0; pda = 0;
    pw[0] = 0; pw[1] = 0; pdout[0] = 0; pdout[1] = 0;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    w = 0;
    while (!rsp_valid && w < 300) begin @(negedge clk); w++; end
    rd = rsp_rdata; hit = rsp_hit;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R11 reset ready", req_ready, 1);
    chk("R11 reset rsp_valid", rsp_valid, 0);
    chk("R3 reset selects", {ata_cs3_n, ata_cs1_n}, 4'hF);
    chk("R3 reset strobes", {ata_rd_n, ata_wr_n}, 4'hF);
  endtask

  task automatic t_legacy_cmd_read;
    logic [31:0] rd; logic h;
    din_base = 16'h5A3C;
    do_io(1'b0, 16'h01F7, 4'h1, 0, rd, h);
    chk("R1 hit", h, 1);
    chk("R1 cs1 ch0", pcs, 4'b0001);
    chk("R1 da", pda, 7);
    chk("R6 setup", gap, 3);
    chk("R6 strobe", pw[0], 8);
    chk("R6 total", tx_cyc, 17);
    chk("R10 R12 byte read", rd, 32'h3C);
    do_io(1'b0, 16'h0173, 4'h1, 0, rd, h);
    chk("R1 cs1 ch1", pcs, 4'b0010);
    chk("R1 da ch1", pda, 3);
  endtask

  task automatic t_legacy_ctl_write;
    logic [31:0] rd; logic h;
    do_io(1'b1, 16'h03F6, 4'h1, 32'h0000_AB04, rd, h);
    chk("R2 cs3 ch0", pcs, 4'b0100);
    chk("R2 da", pda, 6);
    chk("R10 byte write", pdout[0], 16'h0004);
    do_io(1'b1, 16'h0377, 4'h1, 32'h0000_00C5, rd, h);
    chk("R2 cs3 ch1", pcs, 4'b1000);
    chk("R2 da ch1", pda, 7);
  endtask

  task automatic t_native;
    logic [31:0] rd; logic h;
    native_mode = 2'b10;
    native_cmd_base = {16'h0C00, 16'h0000}; native_ctl_base = {16'h0C10, 16'h0000};
    do_io(1'b0, 16'h0172, 4'h1, 0, rd, h);
    chk("R4 legacy ignored hit", h, 0);
    chk("R4 legacy ignored cable", tx_cyc, 0);
    chk("R5 miss data", rd, 0);
    do_io(1'b0, 16'h0C02, 4'h1, 0, rd, h);
    chk("R4 native cmd", pcs, 4'b0010);
    chk("R4 native da", pda, 2);
    do_io(1'b1, 16'h0C12, 4'h1, 32'h11, rd, h);
    chk("R4 native ctl", pcs, 4'b1000);
    chk("R4 native ctl da", pda, 6);
    do_io(1'b0, 16'h01F2, 4'h1, 0, rd, h);
    chk("R4 other channel legacy", pcs, 4'b0001);
    native_mode = 2'b00;
    do_io(1'b0, 16'h0C02, 4'h1, 0, rd, h);
    chk("R4 native ignored in legacy", h, 0);
  endtask

  task automatic t_enable;
    logic [31:0] rd; logic h;
    io_en = 1'b0;
    do_io(1'b0, 16'h01F7, 4'h1, 0, rd, h);
    chk("R5 io off hit", h, 0);
    chk("R5 io off cable", tx_cyc, 0);
    io_en = 1'b1; chan_en = 2'b10;
    do_io(1'b0, 16'h01F7, 4'h1, 0, rd, h);
    chk("R5 chan off hit", h, 0);
    do_io(1'b0, 16'h0177, 4'h1, 0, rd, h);
    chk("R5 other chan on", h, 1);
    chan_en = 2'b11;
  endtask

  task automatic t_fast_and_drive;
    logic [31:0] rd; logic h;
    // drive0: setup 2 strobe 3 recov 1 ; drive1: setup 1 strobe 1 recov 2
    fast_timing = 24'h0 | (24'h09) | (24'h10 << 6);
    fast_en = 4'b0011;
    din_base = 16'h1234;
    do_io(1'b0, 16'h01F0, 4'h3, 0, rd, h);
    chk("R7 setup d0", gap, 2);
    chk("R7 strobe d0", pw[0], 3);
    chk("R7 total d0", tx_cyc, 6);
    chk("R12 word read", rd, 32'h1234);
    do_io(1'b0, 16'h01F1, 4'h1, 0, rd, h);
    chk("R6 non-data stays slow", pw[0], 8);
    do_io(1'b1, 16'h01F6, 4'h1, 32'h10, rd, h);
    do_io(1'b0, 16'h01F0, 4'h3, 0, rd, h);
    chk("R8 drive1 setup", gap, 1);
    chk("R8 drive1 strobe", pw[0], 1);
    chk("R8 drive1 total", tx_cyc, 4);
    do_io(1'b0, 16'h0170, 4'h3, 0, rd, h);
    chk("R8 other channel drive0 compat", tx_cyc, 17);
    fast_en = 4'b0001;
    do_io(1'b0, 16'h01F0, 4'h3, 0, rd, h);
    chk("R6 fast off for drive1", pw[0], 8);
    do_io(1'b1, 16'h01F6, 4'h1, 32'h00, rd, h);
    do_io(1'b0, 16'h01F0, 4'h3, 0, rd, h);
    chk("R8 back to drive0", pw[0], 3);
  endtask

  task automatic t_dword;
    logic [31:0] rd; logic h;
    din_base = 16'h2000;
    do_io(1'b0, 16'h01F0, 4'hF, 0, rd, h);
    chk("R9 two pulses", npulse, 2);
    chk("R9 second width", pw[1], 3);
    chk("R9 total", tx_cyc, 12);
    chk("R9 R12 dword read", rd, 32'h3111_2000);
    do_io(1'b1, 16'h01F0, 4'hF, 32'hBEEF_CAFE, rd, h);
    chk("R9 low half first", pdout[0], 16'hCAFE);
    chk("R9 high half second", pdout[1], 16'hBEEF);
    chk("R3 write strobe", npulse, 2);
  endtask

  task automatic t_backpressure;
    logic [31:0] first;
    int w;
    din_base = 16'h00A5;
    @(negedge clk);
    rsp_ready = 1'b0; npulse = 0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h01F5; req_be = 4'h1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 busy not ready", req_ready, 0);
    w = 0;
    while (!rsp_valid && w < 300) begin @(negedge clk); w++; end
    first = rsp_rdata;
    chk("R11 data", first, 32'hA5);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R11 held valid", rsp_valid, 1);
      chk("R11 held data", rsp_rdata, first);
      chk("R11 not ready while held", req_ready, 0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R11 released", rsp_valid, 0);
    chk("R11 ready again", req_ready, 1);
  endtask

  initial begin
    io_en = 1'b1; chan_en = 2'b11; native_mode = 2'b00;
    native_cmd_base = 0; native_ctl_base = 0; fast_en = 0; fast_timing = 0;
    req_valid = 0; req_write = 0; req_addr = 0; req_be = 0; req_wdata = 0;
    rsp_ready = 1'b1; ata_din = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_legacy_cmd_read();
    t_legacy_ctl_write();
    t_native();
    t_enable();
    t_fast_and_drive();
    t_dword();
    t_backpressure();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule